// File: doc/BRIEF.md
# Debounced Key Wake-Up Detector

This block watches a vector of general-purpose input pins and raises one shared wake interrupt when any watched pin settles at its chosen level for a programmable number of milliseconds. Each pin is set to one of three behaviours: ignored, qualify while high, or qualify while low. The inputs are first brought into the clock domain by a two-flop synchroniser. A free-running prescaler then turns the clock into a millisecond tick, and a single debounce counter checks that the qualifying condition holds across the programmed interval.

When a qualification completes, a sticky pending flag is set. This flag drives the interrupt line, which goes to the processor and to the power controller alike. The flag stays set until software pulses the acknowledge input. While it is set, further qualifications are absorbed and not queued. The interrupt carries no record of which pin caused it. An enable input gates only the output line, so an event caught while the line is disabled appears as soon as the line is enabled again.

Top module: `keywake_top`

## Requirements
- R1: Each pin is sampled through two flip-flops. A pin change cannot affect `wake_irq` before the third rising clock edge after the change.
- R2: Pin i takes its mode from `pin_mode[2i+1:2i]`. 2'b01 qualifies while the synchronised pin is 1, 2'b10 qualifies while it is 0, and 2'b00 or 2'b11 excludes the pin.
- R3: A millisecond tick occurs once every `CLKS_PER_MS` clock cycles, free-running from reset. The debounce counter advances only on ticks.
- R4: With `deb_ms` = D, the qualifying condition must hold through D+1 consecutive ticks. The event is raised on the (D+1)-th tick, so D = 0 qualifies on the first tick.
- R5: If the combined condition drops before qualification, the debounce count restarts from zero.
- R6: Once raised, the pending event stays set until `ack` is 1 at a clock edge, and it is then cleared on that edge.
- R7: A qualification that completes while an event is already pending is absorbed. It leaves nothing behind after the acknowledge.
- R8: If `ack` and a new qualification coincide on one edge, the old event is cleared and the new one holds the line high from the next cycle on.
- R9: `wake_irq` equals the pending flag AND `irq_en`. The pending flag is set and kept regardless of `irq_en`.
- R10: A condition held without a break raises at most one event. A new event needs the condition to drop and qualify again.
- R11: All enabled pins are ORed into one condition and one interrupt. Excluded pins have no effect.
- R12: After reset, `wake_irq` is 0, and the debounce count and tick phase are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pin_mode | input | 2*N_PINS | Per-pin mode: 01 high, 10 low, 00/11 excluded |
| deb_ms | input | DEB_W | Debounce length in ticks minus one |
| irq_en | input | 1 | Interrupt output enable |
| ack | input | 1 | Acknowledge strobe; clears the pending event |
| wake_irq | output | 1 | Shared sticky wake interrupt |

## Verification
A pin change reaches the debounce logic two edges after it is applied. The qualifying edge is the tick edge on which the count has already reached `deb_ms`, and `wake_irq` follows the pending flag combinationally in the same cycle, as do `irq_en` and the effect of `ack` after its edge. The bench drives every input one time unit after a rising edge. It steps a behavioural model on the same edges and compares `wake_irq` at each falling edge, so every latency is checked in the exact cycle it is due. Directed checks for the acknowledge collision line up `ack` with the edge on which the model predicts a qualification.

// File: rtl/kw_pkg.sv
package kw_pkg;
  typedef enum logic [1:0] {
    KW_OFF  = 2'b00,
    KW_HIGH = 2'b01,
    KW_LOW  = 2'b10,
    KW_OFFX = 2'b11
  } kw_mode_e;

  function automatic logic kw_pin_hit(input logic [1:0] mode, input logic lvl);
    return ((mode == KW_HIGH) && lvl) || ((mode == KW_LOW) && !lvl);
  endfunction
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        hold_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        hold_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = hold_q;

  // R1: second stage always takes the previous first-stage value
  p_two_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q == $past(meta_q));
endmodule

// File: rtl/kw_tick.sv
module kw_tick #(
  parameter int DIV = 32000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = (cnt_q == LAST);
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  if (DIV > 1) begin : g_gap
    // R3: ticks are separated by at least one idle cycle
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/kw_qual.sv
module kw_qual
  import kw_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int DEB_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PINS-1:0]     lvl_i,
  input  logic [2*N_PINS-1:0]   mode_i,
  input  logic [DEB_W-1:0]      deb_i,
  input  logic                  tick_i,
  output logic                  fire_o,
  output logic                  cond_o
);
  logic [N_PINS-1:0] hit;
  logic [DEB_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign hit[g] = kw_pin_hit(mode_i[2*g +: 2], lvl_i[g]);
  end

  assign cond_o = |hit;
  assign fire_o = cond_o && tick_i && !done_q && (cnt_q >= deb_i);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!cond_o) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q >= deb_i) done_d = 1'b1;
      else                cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R5: a dropped condition restarts the debounce
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_o |=> (cnt_q == '0) && !done_q);
  // R10: after a qualification no second one while the condition holds
  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && cond_o) |=> !fire_o);
endmodule

// File: rtl/keywake_top.sv
module keywake_top #(
  parameter int N_PINS      = 4,
  parameter int DEB_W       = 8,
  parameter int CLKS_PER_MS = 32000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PINS-1:0]   pin_in,
  input  logic [2*N_PINS-1:0] pin_mode,
  input  logic [DEB_W-1:0]    deb_ms,
  input  logic                irq_en,
  input  logic                ack,
  output logic                wake_irq
);
  logic [N_PINS-1:0] pin_s;
  logic              tick;
  logic              fire;
  logic              cond;
  logic              pend_q, pend_d;

  kw_sync #(.W(N_PINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(pin_s)
  );

  kw_tick #(.DIV(CLKS_PER_MS)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  kw_qual #(.N_PINS(N_PINS), .DEB_W(DEB_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_s), .mode_i(pin_mode),
    .deb_i(deb_ms), .tick_i(tick), .fire_o(fire), .cond_o(cond)
  );

  always_comb begin
    pend_d = (pend_q && !ack) || fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign wake_irq = pend_q && irq_en;

  // R6: pending survives until acknowledged
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);
  // R6: acknowledge without new qualification clears
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire) |=> !pend_q);
  // R8: collision keeps the line raised
  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && fire) |=> pend_q);
  // R4: a new event only follows a qualifying tick with the condition true
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(tick && cond));
endmodule

// File: tb/keywake_tb_top.sv
`timescale 1ns/1ps
module keywake_tb_top;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_in;
  logic [2*N-1:0] pin_mode;
  logic [DW-1:0] deb_ms;
  logic          irq_en;
  logic          ack;
  logic          wake_irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R12";
  bit    cmp_on  = 1'b0;

  always #5 clk = ~clk;

  keywake_top #(.N_PINS(N), .DEB_W(DW), .CLKS_PER_MS(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_mode(pin_mode),
    .deb_ms(deb_ms), .irq_en(irq_en), .ack(ack), .wake_irq(wake_irq)
  );

  // behavioural reference
  logic [N-1:0] m_s1, m_s2;
  int  m_tc, m_cnt;
  bit  m_done, m_pend, m_cond, m_tick, m_fire;

  always @* begin
    m_cond = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pin_mode[2*i +: 2] == 2'b01 && m_s2[i]) m_cond = 1'b1;
      if (pin_mode[2*i +: 2] == 2'b10 && !m_s2[i]) m_cond = 1'b1;
    end
    m_tick = (m_tc == DIV - 1);
    m_fire = m_cond && m_tick && !m_done && (m_cnt >= int'(deb_ms));
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_tc <= 0; m_cnt <= 0;
      m_done <= 1'b0; m_pend <= 1'b0;
    end else begin
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      m_tc <= m_tick ? 0 : m_tc + 1;
      if (!m_cond) begin
        m_cnt <= 0; m_done <= 1'b0;
      end else if (m_tick && !m_done) begin
        if (m_cnt >= int'(deb_ms)) m_done <= 1'b1;
        else m_cnt <= m_cnt + 1;
      end
      m_pend <= (m_pend && !ack) || m_fire;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_tests++;
      if (wake_irq !== (m_pend && irq_en)) begin
        n_fail++;
        $display("FAIL %s: wake_irq actual %b expected %b at %0t",
                 phase, wake_irq, m_pend && irq_en, $time);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(logic exp, string tag);
    @(negedge clk);
    n_tests++;
    if (wake_irq !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_irq actual %b expected %b", tag, wake_irq, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic set_mode(int p, logic [1:0] m);
    pin_mode[2*p +: 2] = m;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; pin_mode = '0; deb_ms = 8'd2;
    irq_en = 1'b1; ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    chk(1'b0, "R12 reset");

    phase = "R2 R4 high";
    set_mode(0, 2'b01); pin_in[0] = 1'b1; step(30);
    chk(1'b1, "R4 high level qualifies");
    phase = "R6"; pin_in[0] = 1'b0; step(10);
    chk(1'b1, "R6 sticky after release");
    do_ack(); step(1);
    chk(1'b0, "R6 ack clears");

    phase = "R10";
    pin_in[0] = 1'b1; step(30); do_ack(); step(30);
    chk(1'b0, "R10 held level fires once");
    pin_in[0] = 1'b0; step(5);

    phase = "R5";
    for (int k = 0; k < 6; k++) begin
      pin_in[0] = 1'b1; step(8); pin_in[0] = 1'b0; step(2);
    end
    chk(1'b0, "R5 short pulses restart");

    phase = "R2 low";
    set_mode(0, 2'b00); pin_in[2] = 1'b1; set_mode(2, 2'b10); step(30);
    chk(1'b0, "R2 low mode ignores high");
    pin_in[2] = 1'b0; step(30);
    chk(1'b1, "R2 low mode qualifies");
    do_ack(); pin_in[2] = 1'b1; step(5);

    phase = "R11";
    set_mode(2, 2'b00); set_mode(1, 2'b11); set_mode(3, 2'b00);
    for (int k = 0; k < 3; k++) begin
      pin_in[1] = 1'b1; pin_in[3] = 1'b1; step(25);
      pin_in[1] = 1'b0; pin_in[3] = 1'b0; step(25);
    end
    chk(1'b0, "R11 excluded pins no effect");
    set_mode(1, 2'b01); pin_in[1] = 1'b1; step(30);
    chk(1'b1, "R11 other pin shares line");
    do_ack(); pin_in[1] = 1'b0; step(5);

    phase = "R9";
    irq_en = 1'b0; pin_in[1] = 1'b1; step(30);
    chk(1'b0, "R9 gated while disabled");
    irq_en = 1'b1;
    chk(1'b1, "R9 held event appears");
    do_ack(); pin_in[1] = 1'b0; step(5);

    phase = "R7";
    pin_in[1] = 1'b1; step(30); pin_in[1] = 1'b0; step(5);
    pin_in[1] = 1'b1; step(30);
    do_ack(); step(1);
    chk(1'b0, "R7 second event absorbed");
    pin_in[1] = 1'b0; step(5);

    phase = "R8";
    pin_in[1] = 1'b1; step(30); pin_in[1] = 1'b0; step(5);
    pin_in[1] = 1'b1;
    for (int k = 0; k < 100 && !m_fire; k++) step(1);
    do_ack(); step(1);
    chk(1'b1, "R8 collision keeps line");
    do_ack(); pin_in[1] = 1'b0; step(5);

    phase = "R1 R4 zero";
    deb_ms = 8'd0; step(4);
    pin_in[1] = 1'b1; step(1);
    chk(1'b0, "R1 no effect within two edges");
    step(3);
    chk(1'b1, "R4 zero debounce first tick");
    do_ack(); pin_in[1] = 1'b0; step(5);

    phase = "R3";
    deb_ms = 8'd3; pin_in[1] = 1'b1; step(12);
    chk(1'b0, "R3 too few ticks");
    step(10);
    chk(1'b1, "R3 enough ticks");
    do_ack(); pin_in[1] = 1'b0; step(5);

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule